// File: doc/BRIEF.md
# Deterministic GCM Nonce Generator

This block supplies 96-bit initialization vectors for AES-GCM. An encryption request receives a value that is built from a fixed salt and an invocation counter. The counter advances by one for every vector the block hands out, so no two encryptions under one salt ever see the same vector. A decryption request carries the vector that the caller already holds. The block returns that vector unchanged and leaves the counter alone.

Software loads a salt, and with it a new key, through the salt port. That load also clears the counter. Each request is a single-cycle strobe. The response appears exactly one cycle later, with a status code and the vector. The caller stores the vector alongside the ciphertext.

The counter never wraps. When it reaches its all-ones value, the block raises an exhaustion flag and refuses every further encryption until a new salt is loaded. Reset clears all state. After reset, encryptions are refused until a salt has been loaded.

Top module: `gcm_nonce_gen`

## Requirements
- R1: A generated vector is IV_W = SALT_W + CNT_W bits wide (96 = 32 + 64 by default). The salt sits in the upper SALT_W bits and the counter value in the lower CNT_W bits.
- R2: `rsp_valid` is high in the cycle after each cycle in which `req_valid` is high, and low after every cycle in which it is not. Requests may arrive on back-to-back cycles.
- R3: An encryption request (`req_decrypt` = 0) made while a salt is loaded and the block is not exhausted returns status 0. Its vector is {salt, counter}, and the counter then increases by exactly one.
- R4: An accepted salt load stores the new salt, sets the counter to zero, clears `exhausted` and raises `armed`. All of this is visible from the next cycle.
- R5: A decryption request (`req_decrypt` = 1) returns status 1 with `rsp_iv` equal to the `req_iv` it carried. It does not change the counter, and it is served even when no salt is loaded or the block is exhausted.
- R6: An encryption request made while no salt has been loaded returns status 2 with an all-zero vector, and the counter does not move.
- R7: The all-ones counter value is never issued. `exhausted` rises in the cycle after the grant that moves the counter to all ones. From then on, encryption requests return status 3 with an all-zero vector until a salt is accepted.
- R8: `salt_ready` is low whenever `req_valid` or `rsp_valid` is high. A `salt_load` made while `salt_ready` is low is ignored: the salt, the counter and `exhausted` all keep their values.
- R9: A synchronous active-high reset clears `armed`, `exhausted` and `rsp_valid`, and sets the counter to zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| salt_load | input | 1 | Strobe to load a new salt |
| salt_in | input | SALT_W | Salt value to load |
| salt_ready | output | 1 | High when a salt load would be accepted |
| req_valid | input | 1 | Request strobe, one request per cycle |
| req_decrypt | input | 1 | 1: decryption pass-through, 0: generate a vector |
| req_iv | input | IV_W | Vector supplied with a decryption request |
| rsp_valid | output | 1 | Response strobe, one cycle after the request |
| rsp_status | output | 2 | 0 fresh, 1 pass-through, 2 no salt, 3 exhausted |
| rsp_iv | output | IV_W | Vector returned to the caller |
| armed | output | 1 | A salt has been loaded since reset |
| exhausted | output | 1 | Counter space used up; encryption refused |

## Verification
The exhaustion boundary is the hardest state to reach. With the default 64-bit counter it lies far beyond any simulation. The bench therefore builds the block with a 4-bit counter and an 8-bit salt. It drives encryptions until fifteen vectors have been issued, and then checks that the sixteenth is refused, that decryptions still pass, and that a new salt revives the block. The refused salt load is the second hard case. It requires `salt_load` in the same cycle as a request, or in the cycle where a response is still outstanding. The bench creates both cases, then issues an encryption to show that the old salt and counter survived.

// File: rtl/nonce_pkg.sv
package nonce_pkg;

    localparam int SALT_W_DEFAULT = 32;
    localparam int CNT_W_DEFAULT  = 64;

    typedef enum logic [1:0] {
        NS_FRESH  = 2'd0,
        NS_PASS   = 2'd1,
        NS_NOSALT = 2'd2,
        NS_SPENT  = 2'd3
    } nonce_status_e;

    typedef struct packed {
        logic          take_count;
        nonce_status_e code;
    } nonce_verdict_t;

    function automatic nonce_verdict_t judge_request(
        input logic is_dec,
        input logic have_salt,
        input logic used_up
    );
        nonce_verdict_t v;
        v.take_count = 1'b0;
        if (is_dec) begin
            v.code = NS_PASS;
        end else if (!have_salt) begin
            v.code = NS_NOSALT;
        end else if (used_up) begin
            v.code = NS_SPENT;
        end else begin
            v.code       = NS_FRESH;
            v.take_count = 1'b1;
        end
        return v;
    endfunction

endpackage

// File: rtl/nonce_salt_reg.sv
module nonce_salt_reg #(
    parameter int SALT_W = nonce_pkg::SALT_W_DEFAULT
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load_req,
    input  logic              busy,
    input  logic [SALT_W-1:0] salt_in,
    output logic              load_take,
    output logic [SALT_W-1:0] salt_q,
    output logic              armed_q
);

    assign load_take = load_req && !busy;

    always_ff @(posedge clk) begin
        if (rst) begin
            salt_q  <= '0;
            armed_q <= 1'b0;
        end else if (load_take) begin
            salt_q  <= salt_in;
            armed_q <= 1'b1;
        end
    end

endmodule

// File: rtl/nonce_ctr.sv
module nonce_ctr #(
    parameter int CNT_W = nonce_pkg::CNT_W_DEFAULT
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clear,
    input  logic             bump,
    output logic [CNT_W-1:0] cnt_q,
    output logic             spent_q
);

    localparam logic [CNT_W-1:0] CNT_TOP = {CNT_W{1'b1}};
    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

    logic [CNT_W-1:0] cnt_inc;

    assign cnt_inc = cnt_q + CNT_ONE;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q   <= '0;
            spent_q <= 1'b0;
        end else if (clear) begin
            cnt_q   <= '0;
            spent_q <= 1'b0;
        end else if (bump && !spent_q) begin
            cnt_q   <= cnt_inc;
            spent_q <= (cnt_inc == CNT_TOP);
        end
    end

endmodule

// File: rtl/nonce_issue.sv
module nonce_issue
    import nonce_pkg::*;
#(
    parameter int SALT_W = SALT_W_DEFAULT,
    parameter int CNT_W  = CNT_W_DEFAULT,
    localparam int IV_W  = SALT_W + CNT_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic              req_dec,
    input  logic [IV_W-1:0]   req_iv,
    input  logic [SALT_W-1:0] salt,
    input  logic [CNT_W-1:0]  cnt,
    input  logic              armed,
    input  logic              spent,
    output logic              bump,
    output logic              rsp_valid_q,
    output nonce_status_e     rsp_code_q,
    output logic [IV_W-1:0]   rsp_iv_q
);

    nonce_verdict_t  verdict;
    logic [IV_W-1:0] iv_next;

    always_comb begin
        verdict = judge_request(req_dec, armed, spent);
        bump    = req_valid && verdict.take_count;
        case (verdict.code)
            NS_FRESH: iv_next = {salt, cnt};
            NS_PASS:  iv_next = req_iv;
            default:  iv_next = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid_q <= 1'b0;
            rsp_code_q  <= NS_FRESH;
            rsp_iv_q    <= '0;
        end else begin
            rsp_valid_q <= req_valid;
            if (req_valid) begin
                rsp_code_q <= verdict.code;
                rsp_iv_q   <= iv_next;
            end
        end
    end

endmodule

// File: rtl/gcm_nonce_gen.sv
module gcm_nonce_gen
    import nonce_pkg::*;
#(
    parameter int SALT_W = SALT_W_DEFAULT,
    parameter int CNT_W  = CNT_W_DEFAULT,
    localparam int IV_W  = SALT_W + CNT_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              salt_load,
    input  logic [SALT_W-1:0] salt_in,
    output logic              salt_ready,
    input  logic              req_valid,
    input  logic              req_decrypt,
    input  logic [IV_W-1:0]   req_iv,
    output logic              rsp_valid,
    output logic [1:0]        rsp_status,
    output logic [IV_W-1:0]   rsp_iv,
    output logic              armed,
    output logic              exhausted
);

    logic              busy;
    logic              load_take;
    logic [SALT_W-1:0] salt_q;
    logic              armed_q;
    logic [CNT_W-1:0]  cnt_q;
    logic              spent_q;
    logic              bump;
    nonce_status_e     rsp_code_q;

    assign busy       = req_valid || rsp_valid;
    assign salt_ready = !busy;

    nonce_salt_reg #(.SALT_W(SALT_W)) u_salt (
        .clk       (clk),
        .rst       (rst),
        .load_req  (salt_load),
        .busy      (busy),
        .salt_in   (salt_in),
        .load_take (load_take),
        .salt_q    (salt_q),
        .armed_q   (armed_q)
    );

    nonce_ctr #(.CNT_W(CNT_W)) u_ctr (
        .clk     (clk),
        .rst     (rst),
        .clear   (load_take),
        .bump    (bump),
        .cnt_q   (cnt_q),
        .spent_q (spent_q)
    );

    nonce_issue #(.SALT_W(SALT_W), .CNT_W(CNT_W)) u_issue (
        .clk         (clk),
        .rst         (rst),
        .req_valid   (req_valid),
        .req_dec     (req_decrypt),
        .req_iv      (req_iv),
        .salt        (salt_q),
        .cnt         (cnt_q),
        .armed       (armed_q),
        .spent       (spent_q),
        .bump        (bump),
        .rsp_valid_q (rsp_valid),
        .rsp_code_q  (rsp_code_q),
        .rsp_iv_q    (rsp_iv)
    );

    assign rsp_status = rsp_code_q;
    assign armed      = armed_q;
    assign exhausted  = spent_q;

endmodule

// File: rtl/nonce_gen_chk.sv
module nonce_gen_chk
    import nonce_pkg::*;
#(
    parameter int SALT_W = SALT_W_DEFAULT,
    parameter int CNT_W  = CNT_W_DEFAULT,
    localparam int IV_W  = SALT_W + CNT_W
) (
    input logic              clk,
    input logic              rst,
    input logic              salt_load,
    input logic              salt_ready,
    input logic              req_valid,
    input logic              req_decrypt,
    input logic [IV_W-1:0]   req_iv,
    input logic              rsp_valid,
    input logic [1:0]        rsp_status,
    input logic [IV_W-1:0]   rsp_iv,
    input logic              armed,
    input logic              exhausted,
    input logic [SALT_W-1:0] salt_q,
    input logic [CNT_W-1:0]  cnt_q
);

    localparam logic [CNT_W-1:0] ALL_ONES = {CNT_W{1'b1}};
    localparam logic [CNT_W-1:0] ONE      = CNT_W'(1);

    AST_RSP_LATENCY: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> rsp_valid);  // R2
    AST_NO_SPURIOUS_RSP: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> !rsp_valid);  // R2
    AST_FRESH_LAYOUT: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_status == NS_FRESH) |->
            (rsp_iv[IV_W-1:CNT_W] == salt_q && rsp_iv[CNT_W-1:0] == cnt_q - ONE));  // R3
    AST_PASS_THROUGH: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_decrypt) |=>
            (rsp_status == NS_PASS && rsp_iv == $past(req_iv)));  // R5
    AST_NOSALT_DENY: assert property (@(posedge clk) disable iff (rst)
        (!armed && req_valid && !req_decrypt) |=> (rsp_status == NS_NOSALT && rsp_iv == '0));  // R6
    AST_NO_TOP_VALUE: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_status == NS_FRESH) |-> rsp_iv[CNT_W-1:0] != ALL_ONES);  // R7
    AST_SPENT_STICKY: assert property (@(posedge clk) disable iff (rst)
        (exhausted && !salt_load) |=> exhausted);  // R7
    AST_LOAD_RESTART: assert property (@(posedge clk) disable iff (rst)
        (salt_load && salt_ready) |=> (armed && !exhausted && cnt_q == '0));  // R4
    AST_SALT_HOLD: assert property (@(posedge clk) disable iff (rst)
        (salt_load && !salt_ready) |=> $stable(salt_q));  // R8

endmodule

bind gcm_nonce_gen nonce_gen_chk #(.SALT_W(SALT_W), .CNT_W(CNT_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .salt_load   (salt_load),
    .salt_ready  (salt_ready),
    .req_valid   (req_valid),
    .req_decrypt (req_decrypt),
    .req_iv      (req_iv),
    .rsp_valid   (rsp_valid),
    .rsp_status  (rsp_status),
    .rsp_iv      (rsp_iv),
    .armed       (armed),
    .exhausted   (exhausted),
    .salt_q      (salt_q),
    .cnt_q       (cnt_q)
);

// File: tb/sim_gcm_nonce_gen.sv
module sim_gcm_nonce_gen;

    localparam int SW = 8;
    localparam int CW = 4;
    localparam int IW = SW + CW;
    localparam logic [CW-1:0] CTOP = {CW{1'b1}};

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          salt_load = 1'b0;
    logic [SW-1:0] salt_in = '0;
    logic          salt_ready;
    logic          req_valid = 1'b0;
    logic          req_decrypt = 1'b0;
    logic [IW-1:0] req_iv = '0;
    logic          rsp_valid;
    logic [1:0]    rsp_status;
    logic [IW-1:0] rsp_iv;
    logic          armed;
    logic          exhausted;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    // scoreboard queues
    logic [1:0]    exp_st_q[$];
    logic [IW-1:0] exp_iv_q[$];
    string         exp_tag_q[$];

    // bench model
    logic [SW-1:0] m_salt  = '0;
    logic [CW-1:0] m_cnt   = '0;
    bit            m_armed = 1'b0;
    bit            m_exh   = 1'b0;

    always #10 clk = ~clk;

    gcm_nonce_gen #(.SALT_W(SW), .CNT_W(CW)) u0 (
        .clk(clk), .rst(rst), .salt_load(salt_load), .salt_in(salt_in),
        .salt_ready(salt_ready), .req_valid(req_valid), .req_decrypt(req_decrypt),
        .req_iv(req_iv), .rsp_valid(rsp_valid), .rsp_status(rsp_status),
        .rsp_iv(rsp_iv), .armed(armed), .exhausted(exhausted)
    );

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // monitor: pop and compare each response
    always @(negedge clk) begin
        if (!rst && rsp_valid && !done) begin
            if (exp_st_q.size() == 0) begin
                check(1'b0, "R2 unexpected response", 32'(rsp_status), 32'hFFFF);
            end else begin
                logic [1:0]    es;
                logic [IW-1:0] ei;
                string         et;
                es = exp_st_q.pop_front();
                ei = exp_iv_q.pop_front();
                et = exp_tag_q.pop_front();
                check(rsp_status == es, {et, " status"}, 32'(rsp_status), 32'(es));
                check(rsp_iv == ei, {et, " iv"}, 32'(rsp_iv), 32'(ei));
            end
        end
    end

    task automatic push(input logic [1:0] st, input logic [IW-1:0] iv, input string tag);
        exp_st_q.push_back(st);
        exp_iv_q.push_back(iv);
        exp_tag_q.push_back(tag);
    endtask

    task automatic model_enc(input string tag);
        if (!m_armed) begin
            push(2'd2, '0, {tag, " R6"});
        end else if (m_exh) begin
            push(2'd3, '0, {tag, " R7"});
        end else begin
            push(2'd0, {m_salt, m_cnt}, {tag, " R1 R3"});
            m_cnt = m_cnt + 1'b1;
            if (m_cnt == CTOP) m_exh = 1'b1;
        end
    endtask

    task automatic enc(input string tag);
        @(negedge clk);
        salt_load   = 1'b0;
        req_valid   = 1'b1;
        req_decrypt = 1'b0;
        req_iv      = '0;
        model_enc(tag);
    endtask

    task automatic dec(input logic [IW-1:0] iv, input string tag);
        @(negedge clk);
        salt_load   = 1'b0;
        req_valid   = 1'b1;
        req_decrypt = 1'b1;
        req_iv      = iv;
        push(2'd1, iv, {tag, " R5"});
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            req_valid   = 1'b0;
            req_decrypt = 1'b0;
            salt_load   = 1'b0;
        end
    endtask

    task automatic load_salt(input logic [SW-1:0] s, input bit expect_ok, input string tag);
        @(negedge clk);
        req_valid = 1'b0;
        salt_load = 1'b1;
        salt_in   = s;
        #1;
        check(salt_ready == expect_ok, {tag, " salt_ready"}, 32'(salt_ready), 32'(expect_ok));
        if (expect_ok) begin
            m_salt  = s;
            m_cnt   = '0;
            m_armed = 1'b1;
            m_exh   = 1'b0;
        end
    endtask

    // salt load in the same cycle as an encryption: must be ignored (R8)
    task automatic enc_with_salt(input logic [SW-1:0] s);
        @(negedge clk);
        req_valid   = 1'b1;
        req_decrypt = 1'b0;
        salt_load   = 1'b1;
        salt_in     = s;
        #1;
        check(salt_ready == 1'b0, "R8 ready low with request", 32'(salt_ready), 32'd0);
        model_enc("R8 enc beside salt");
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        check(1'b0, "watchdog expired", 32'd0, 32'd1);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        check(rsp_valid == 1'b0, "R9 rsp_valid after reset", 32'(rsp_valid), 32'd0);
        check(armed == 1'b0, "R9 armed after reset", 32'(armed), 32'd0);
        check(exhausted == 1'b0, "R9 exhausted after reset", 32'(exhausted), 32'd0);
        check(salt_ready == 1'b1, "R8 ready when idle", 32'(salt_ready), 32'd1);

        // no salt yet
        enc("no salt");
        dec(12'hABC, "pass before salt");
        idle(2);
        check(armed == 1'b0, "R6 still unarmed", 32'(armed), 32'd0);

        // load and issue
        load_salt(8'hA5, 1'b1, "R4 first load");
        idle(1);
        check(armed == 1'b1, "R4 armed after load", 32'(armed), 32'd1);
        check(exhausted == 1'b0, "R4 not exhausted", 32'(exhausted), 32'd0);
        enc("first");
        enc("second back-to-back R2");
        dec(12'h123, "between");
        enc("after dec");
        idle(2);

        // refused salt loads (R8)
        enc_with_salt(8'h3C);
        load_salt(8'h77, 1'b0, "R8 load during response");
        idle(1);
        enc("after refused loads R8");
        idle(2);

        // drive to exhaustion (R7)
        while (!m_exh) enc("fill");
        idle(2);
        check(exhausted == 1'b1, "R7 exhausted raised", 32'(exhausted), 32'd1);
        enc("refused");
        dec(12'h5A5, "pass while exhausted");
        enc("refused again");
        idle(2);
        check(exhausted == 1'b1, "R7 stays exhausted", 32'(exhausted), 32'd1);

        // new salt revives (R4)
        load_salt(8'h5A, 1'b1, "R4 reload");
        idle(1);
        check(exhausted == 1'b0, "R4 exhausted cleared", 32'(exhausted), 32'd0);
        enc("revived");
        enc("revived two");
        idle(2);

        // reset in the middle (R9)
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        m_armed = 1'b0; m_exh = 1'b0; m_cnt = '0; m_salt = '0;
        #1;
        check(armed == 1'b0, "R9 armed cleared", 32'(armed), 32'd0);
        check(rsp_valid == 1'b0, "R9 rsp cleared", 32'(rsp_valid), 32'd0);
        enc("after reset R9");
        idle(3);

        check(exp_st_q.size() == 0, "R2 every request answered", 32'(exp_st_q.size()), 32'd0);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule